// File: doc/BRIEF.md
# Single-Source Interrupt Trigger Controller

The block watches one asynchronous interrupt line and turns it into a single request toward a parent interrupt controller. Software chooses one of four trigger conditions through a two-bit mode field: low level, high level, falling edge or rising edge. The line is brought into the clock domain by a two-stage synchronizer. The chosen condition sets a sticky pending flag. The request output is asserted while that flag is set and the line is unmasked.

Three word registers sit on a simple synchronous bus. They hold the mode, the mask and the pending flag. Software acknowledges the request by writing a one to the pending flag. In the edge modes this is done before the handler runs. In the level modes it is done at the end of service, and the flag comes straight back if the line still holds its active level. The pending flag is recorded even while the line is masked, so unmasking later delivers the request at once.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset the mode word, the enable bit and the pending flag are all zero, and `irq_o` is low.
- R2: Byte addresses are decoded in full. The mode word is at 0x0, enable at 0x4 and pending at 0x8. A read returns data on `rdata_o` one clock after `rd_en_i`. Any other address reads as zero.
- R3: A write to 0x0 stores the whole data word, and it reads back unchanged. Bits [1:0] select the trigger: 0 low level, 1 falling edge, 2 high level, 3 rising edge.
- R4: The line passes through two flip-flops. A change driven between clock edges sets the pending flag on the third rising clock edge after the change, and not before.
- R5: In rising-edge mode only a low-to-high transition sets pending. A steady high line and a falling transition do not.
- R6: In falling-edge mode only a high-to-low transition sets pending.
- R7: In high-level mode pending is set on every cycle the synchronized line is high. An acknowledge while the line is still high leaves the flag set.
- R8: In low-level mode pending is set on every cycle the synchronized line is low. Once the line returns high, an acknowledge clears it.
- R9: Writing 1 in bit 0 at 0x8 clears the pending flag. Writing 0 there leaves it unchanged.
- R10: If an acknowledge and a detected trigger fall in the same cycle, the flag stays set.
- R11: `irq_o` equals the pending flag ANDed with the enable bit. The pending flag is set even while the enable bit is 0.
- R12: A mode write alone, with the line held steady, does not set pending in an edge mode.
- R13: Only bit 0 of the enable word is stored. Bits [31:1] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw interrupt line, asynchronous |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the parent controller |

## Verification
The case that needs care is a software acknowledge landing in the same cycle that the detector reports a new trigger. The acknowledge must lose, or the event is dropped. The bench lines these up on purpose: it drives a rising edge, counts the two synchronizer stages, and places the pending write in exactly the cycle in which the edge reaches the detector. It then reads the flag back and expects it to be set. The same collision happens in high-level mode whenever the line is still active during the acknowledge. A long random run also brings acknowledges, mode changes and line toggles together in the same cycle. In that run a cycle-level model built from the requirements predicts `irq_o` and every read value.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  localparam int unsigned OFF_MODE = 0;
  localparam int unsigned OFF_EN   = 4;
  localparam int unsigned OFF_PEND = 8;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  p_stage_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_q[STAGES-1] == $past(stg_q[STAGES-2]));

endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_trig_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  trig_mode_e mode_i,
  input  logic       line_i,
  output logic       evt_o
);

  logic hist_q;

  // history always tracks the sample, so a mode change never sees a stale value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= RST_VAL;
    else         hist_q <= line_i;
  end

  always_comb begin
    unique case (mode_i)
      TRIG_LVL_LO:    evt_o = ~line_i;
      TRIG_LVL_HI:    evt_o = line_i;
      TRIG_EDGE_FALL: evt_o = hist_q & ~line_i;
      TRIG_EDGE_RISE: evt_o = ~hist_q & line_i;
      default:        evt_o = 1'b0;
    endcase
  end

  p_edge_needs_change_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (mode_i == TRIG_EDGE_RISE || mode_i == TRIG_EDGE_FALL))
      |-> (line_i != $past(line_i)));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_trig_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic              evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output trig_mode_e        mode_o,
  output logic              en_o,
  output logic              pend_o
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);

  logic [DATA_W-1:0] mode_q, rdata_q, rd_mux;
  logic              en_q, pend_q;
  logic              wr_mode, wr_en, ack;

  assign wr_mode = wr_en_i && (addr_i == A_MODE);
  assign wr_en   = wr_en_i && (addr_i == A_EN);
  assign ack     = wr_en_i && (addr_i == A_PEND) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata_i;
      if (wr_en)   en_q   <= wdata_i[0];
    end
  end

  // a fresh trigger takes priority over the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (evt_i) pend_q <= 1'b1;
    else if (ack)   pend_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_MODE)      rd_mux = mode_q;
    else if (addr_i == A_EN)   rd_mux = DATA_W'(en_q);
    else if (addr_i == A_PEND) rd_mux = DATA_W'(pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign mode_o  = trig_mode_e'(mode_q[1:0]);
  assign en_o    = en_q;
  assign pend_o  = pend_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_q);
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !evt_i) |=> !pend_q);
  p_rise_has_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(evt_i));
  p_en_bit_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(wdata_i[0])));
  p_mode_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
  import irq_trig_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  // idle level matches the reset mode (low level), so reset does not fire
  localparam logic IDLE_LVL = 1'b1;

  logic       line_s, evt, en, pend;
  trig_mode_e mode;

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (line_s)
  );

  irq_detect #(.RST_VAL(IDLE_LVL)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .line_i (line_s),
    .evt_o  (evt)
  );

  irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en_i),
    .evt_i   (evt),
    .rdata_o (rdata_o),
    .mode_o  (mode),
    .en_o    (en),
    .pend_o  (pend)
  );

  assign irq_o = pend & en;

  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_o);
  p_irq_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && pend) |-> irq_o);

endmodule

// File: tb/sim_irq_trig_ctrl.sv
module sim_irq_trig_ctrl;

  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rd = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  irq_trig_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .addr_i(addr),
    .wr_en_i(wr), .wdata_i(wdata), .rd_en_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---- reference model built from the requirements ----
  logic          m_s1, m_s2, m_h, m_en, m_pend, m_rdv;
  logic [DW-1:0] m_mode, m_rd;

  function automatic logic f_evt(input logic [1:0] md, input logic s, input logic h);
    case (md)
      2'd0:    return !s;
      2'd1:    return h && !s;
      2'd2:    return s;
      default: return !h && s;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_read(input logic [AW-1:0] a);
    if (a == 4'h0) return m_mode;
    if (a == 4'h4) return DW'(m_en);
    if (a == 4'h8) return DW'(m_pend);
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_h <= 1'b1;
      m_en <= 1'b0; m_pend <= 1'b0; m_mode <= '0; m_rd <= '0; m_rdv <= 1'b0;
    end else begin
      m_s1 <= line; m_s2 <= m_s1; m_h <= m_s2;
      if (wr && addr == 4'h0) m_mode <= wdata;
      if (wr && addr == 4'h4) m_en <= wdata[0];
      if (f_evt(m_mode[1:0], m_s2, m_h)) m_pend <= 1'b1;
      else if (wr && addr == 4'h8 && wdata[0]) m_pend <= 1'b0;
      m_rdv <= rd;
      if (rd) m_rd <= f_read(addr);
    end
  end

  always @(negedge clk) if (model_on) begin
    chk(irq === (m_pend & m_en), "R11 irq model", DW'(irq), DW'(m_pend & m_en));
    if (m_rdv) chk(rdata === m_rd, "R2 read model", rdata, m_rd);
  end

  // ---- bus tasks ----
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_line(input logic v, input int waitc);
    @(negedge clk); line = v;
    repeat (waitc) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    logic [DW-1:0] d;
    bus_rd(a, d);
    chk(d === e, tag, d, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(irq === 1'b0, "R1 irq in reset", DW'(irq), 0);
    rst_n = 1'b1;
    model_on = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq === 1'b0, "R1 irq after reset", DW'(irq), 0);
    expect_rd(4'h0, 0, "R1 mode reset");
    expect_rd(4'h4, 0, "R1 enable reset");
    expect_rd(4'h8, 0, "R1 pending reset");

    // R13 enable only bit 0
    bus_wr(4'h4, 32'hFFFF_FFFF);
    expect_rd(4'h4, 1, "R13 enable upper bits");
    bus_wr(4'h4, 32'hFFFF_FFFE);
    expect_rd(4'h4, 0, "R13 enable bit0 clear");

    // R3 full word readback, mode=3 rising; R12 no spurious event with line steady high
    bus_wr(4'h0, 32'hA5C3_5A7B);
    expect_rd(4'h0, 32'hA5C3_5A7B, "R3 mode word readback");
    repeat (3) @(negedge clk);
    expect_rd(4'h8, 0, "R12 mode write alone");

    // R5 falling edge ignored in rising mode
    bus_wr(4'h4, 1);
    set_line(1'b0, 5);
    expect_rd(4'h8, 0, "R5 fall ignored");

    // R4 latency: change between edges, set on third edge
    @(negedge clk); line = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(irq === 1'b0, "R4 not before third edge", DW'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1, "R4 set on third edge", DW'(irq), 1);

    // R9 ack with 0 ignored, with 1 clears; R5 steady high no re-set
    bus_wr(4'h8, 32'hFFFF_FFFE);
    expect_rd(4'h8, 1, "R9 write zero no effect");
    bus_wr(4'h8, 1);
    repeat (4) @(negedge clk);
    expect_rd(4'h8, 0, "R9/R5 cleared, steady high");

    // R6 falling mode
    bus_wr(4'h0, 1);
    set_line(1'b1, 3);
    expect_rd(4'h8, 0, "R6 nothing while high");
    set_line(1'b0, 4);
    expect_rd(4'h8, 1, "R6 fall sets");
    bus_wr(4'h8, 1);
    set_line(1'b1, 4);
    expect_rd(4'h8, 0, "R6 rise ignored");

    // R7 high level: ack while high stays set
    bus_wr(4'h0, 2);
    repeat (2) @(negedge clk);
    bus_wr(4'h8, 1);
    expect_rd(4'h8, 1, "R7 ack while high");
    set_line(1'b0, 4);
    bus_wr(4'h8, 1);
    expect_rd(4'h8, 0, "R7 ack after drop");

    // R8 low level
    bus_wr(4'h0, 0);
    repeat (2) @(negedge clk);
    bus_wr(4'h8, 1);
    expect_rd(4'h8, 1, "R8 ack while low");
    set_line(1'b1, 4);
    bus_wr(4'h8, 1);
    expect_rd(4'h8, 0, "R8 ack after rise");

    // R11 pending latched while masked
    bus_wr(4'h0, 3);
    bus_wr(4'h4, 0);
    set_line(1'b0, 4);
    set_line(1'b1, 4);
    chk(irq === 1'b0, "R11 masked irq", DW'(irq), 0);
    expect_rd(4'h8, 1, "R11 pending while masked");
    bus_wr(4'h4, 1);
    @(negedge clk);
    chk(irq === 1'b1, "R11 unmask delivers", DW'(irq), 1);

    // R10 ack and edge in the same cycle
    set_line(1'b0, 4);
    @(negedge clk); line = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 4'h8; wdata = 1; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    expect_rd(4'h8, 1, "R10 set wins");
    chk(irq === 1'b1, "R10 irq kept", DW'(irq), 1);

    // R2 unmapped addresses
    expect_rd(4'hC, 0, "R2 unmapped 0xC");
    expect_rd(4'h2, 0, "R2 unmapped 0x2");
    expect_rd(4'h5, 0, "R2 unmapped 0x5");

    // R12 edge-mode switch with steady line
    bus_wr(4'h8, 1);
    bus_wr(4'h0, 1);
    bus_wr(4'h0, 3);
    repeat (3) @(negedge clk);
    expect_rd(4'h8, 0, "R12 mode switches steady line");

    // random phase, checked by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      if ($urandom_range(3) == 0) line = ~line;
      case ($urandom_range(7))
        0: begin addr = 4'h0; wdata = $urandom; wr = 1'b1; end
        1: begin addr = 4'h4; wdata = $urandom; wr = 1'b1; end
        2: begin addr = 4'h8; wdata = $urandom; wr = 1'b1; end
        3, 4: begin addr = AW'($urandom_range(15)); rd = 1'b1; end
        5: begin addr = 4'h8; rd = 1'b1; end
        default: ;
      endcase
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule